// File: doc/BRIEF.md
# Black Level Clamp Feedback Loop

This block closes a digital feedback loop around an image sensor front end. It holds the converter's black level at a programmed target. A clamp strobe marks the shielded black pixels on each line. While the strobe is active, every valid 12-bit converter sample is compared with an 8-bit target level, and the signed difference is summed. When the strobe window closes, the sum is scaled down by a power of two, which acts as a low-pass filter and sets the loop gain. The scaled sum is then added to a correction code. That code drives an offset DAC ahead of the converter, so a sample below target raises the correction.

The strobe polarity is selectable. A window that carries too few samples is discarded. The correction saturates at the DAC code range. When the loop is switched off, it stops tracking and keeps its code. In that state the output carries the target level, zero-extended, as a fixed offset. The sample input is a valid/ready stream that never applies back-pressure: `smp_ready` is held high, and a sample transfers in every cycle where `smp_valid` is high.

Top module: `blk_clamp_loop`

## Requirements
- R1: After reset, with the loop enabled, `dac_code` equals midscale (2^(DAC_W-1), 512 for DAC_W = 10).
- R2: `smp_ready` is 1 in every cycle out of reset, so a sample transfers whenever `smp_valid` is 1.
- R3: The strobe is active when `clamp_strobe` equals `strobe_high`: 1 selects active high and 0 selects active low.
- R4: Only samples with `smp_valid` = 1, taken while the strobe is active and the loop is enabled, contribute the error (level − sample). Samples outside the window have no effect on the correction.
- R5: The correction changes only after a window closes. The close cycle is the first cycle in which the strobe is inactive after being active. In the cycle after the close, `dac_code` becomes the clipped value of code + floor(sum / 2^STEP_SHIFT), with STEP_SHIFT = 4 by default.
- R6: A window with fewer than MIN_WIN valid samples (2 by default) leaves the correction unchanged.
- R7: The correction saturates at 0 and at 2^DAC_W − 1 (1023) and never wraps.
- R8: With `clamp_en` = 0, `dac_code` equals `clamp_level` zero-extended. The loop code holds and no error is gathered. When `clamp_en` returns to 1, the held loop code appears again.
- R9: Apart from window closes with the loop enabled, the loop code is stable from cycle to cycle.
- R10: Within one window, only the first 2^CNT_W − 1 valid samples (255 by default) are summed. Further samples in the same window are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Always 1; the block never back-pressures |
| smp_data | input | DATA_W (12) | Converter sample, straight binary |
| clamp_strobe | input | 1 | Black-pixel clamp strobe |
| strobe_high | input | 1 | 1 = strobe active high, 0 = active low |
| clamp_en | input | 1 | 1 = loop tracks, 0 = fixed offset from level |
| clamp_level | input | LEVEL_W (8) | Target black level in LSB |
| dac_code | output | DAC_W (10) | Correction word to the offset DAC |

## Verification
The bench sweeps both strobe polarities, both contiguous and every-other-cycle valid patterns, window lengths of 0 to 6 samples, and several target levels. The sample values give errors of both signs. These runs separate a correct window gate, sample count and floor scaling from off-by-one or rounding faults. Directed runs cover the following cases:
- Large errors repeated until both rails are reached, which exposes wrap-around.
- A 300-sample window, which separates a capped sample count from an uncapped one.
- Valid samples outside the window, which must leave the code unchanged.
- Windows while the loop is disabled, after which the held code must reappear.

// File: rtl/blk_clamp_pkg.sv
package blk_clamp_pkg;

  // Window close event handed from the window tracker to the updater
  typedef struct packed {
    logic close;      // first inactive cycle after an active one
    logic qualified;  // enough valid samples were gathered
  } win_evt_t;

endpackage

// File: rtl/blk_clamp_window.sv
module blk_clamp_window
  import blk_clamp_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MIN_WIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clamp_strobe,
  input  logic             strobe_high,
  input  logic             clamp_en,
  input  logic             smp_valid,
  output logic             take,
  output win_evt_t         evt,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_WIN);

  logic active, active_q;

  assign active    = strobe_high ? clamp_strobe : ~clamp_strobe;
  assign take      = active & smp_valid & clamp_en & (count != CNT_MAX);
  assign evt.close = active_q & ~active;
  assign evt.qualified = (count >= CNT_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      count    <= '0;
    end else begin
      active_q <= active;
      if (evt.close || !clamp_en) count <= '0;
      else if (take)              count <= count + 1'b1;
    end
  end

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !evt.close && clamp_en) |=> (count == CNT_MAX));

endmodule

// File: rtl/blk_clamp_accum.sv
module blk_clamp_accum #(
  parameter int DATA_W  = 12,
  parameter int LEVEL_W = 8,
  parameter int ACC_W   = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic                     clear,
  input  logic [DATA_W-1:0]        smp_data,
  input  logic [LEVEL_W-1:0]       clamp_level,
  output logic signed [ACC_W-1:0]  acc
);
  localparam int ERR_W = DATA_W + 1;

  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W-1:0] err_ext;

  assign err = $signed({1'b0, {(DATA_W-LEVEL_W){1'b0}}, clamp_level})
             - $signed({1'b0, smp_data});
  assign err_ext = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (take)   acc <= acc + err_ext;
  end

  // R4
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> $stable(acc));

endmodule

// File: rtl/blk_clamp_update.sv
module blk_clamp_update
  import blk_clamp_pkg::*;
#(
  parameter int ACC_W      = 21,
  parameter int DAC_W      = 10,
  parameter int STEP_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  win_evt_t                evt,
  input  logic                    clamp_en,
  input  logic signed [ACC_W-1:0] acc,
  output logic [DAC_W-1:0]        code
);
  localparam int SUM_W = ACC_W + 1;
  localparam logic [DAC_W-1:0] MID_CODE = DAC_W'(1 << (DAC_W - 1));
  localparam logic signed [SUM_W-1:0] TOP = $signed(SUM_W'((1 << DAC_W) - 1));

  logic signed [ACC_W-1:0] step;
  logic signed [SUM_W-1:0] nxt;
  logic [DAC_W-1:0]        clipped;
  logic                    apply;

  assign step  = acc >>> STEP_SHIFT;
  assign nxt   = $signed({{(SUM_W-DAC_W){1'b0}}, code}) + $signed({step[ACC_W-1], step});
  assign apply = evt.close & evt.qualified & clamp_en;

  always_comb begin
    if (nxt[SUM_W-1])   clipped = '0;
    else if (nxt > TOP) clipped = {DAC_W{1'b1}};
    else                clipped = nxt[DAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     code <= MID_CODE;
    else if (apply) code <= clipped;
  end

  // R7
  sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !step[ACC_W-1]) |=> (code >= $past(code)));
  // R7
  sat_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && step[ACC_W-1]) |=> (code <= $past(code)));
  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.close && clamp_en) |=> $stable(code));

endmodule

// File: rtl/blk_clamp_loop.sv
module blk_clamp_loop
  import blk_clamp_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LEVEL_W    = 8,
  parameter int DAC_W      = 10,
  parameter int CNT_W      = 8,
  parameter int MIN_WIN    = 2,
  parameter int STEP_SHIFT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [DATA_W-1:0]  smp_data,
  input  logic               clamp_strobe,
  input  logic               strobe_high,
  input  logic               clamp_en,
  input  logic [LEVEL_W-1:0] clamp_level,
  output logic [DAC_W-1:0]   dac_code
);
  localparam int ACC_W = DATA_W + 1 + CNT_W;

  logic                    take;
  win_evt_t                evt;
  logic [CNT_W-1:0]        count;
  logic signed [ACC_W-1:0] acc;
  logic [DAC_W-1:0]        loop_code;

  assign smp_ready = 1'b1;

  blk_clamp_window #(.CNT_W(CNT_W), .MIN_WIN(MIN_WIN)) u_window (
    .clk(clk), .rst_n(rst_n), .clamp_strobe(clamp_strobe),
    .strobe_high(strobe_high), .clamp_en(clamp_en), .smp_valid(smp_valid),
    .take(take), .evt(evt), .count(count)
  );

  blk_clamp_accum #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .clear(evt.close | ~clamp_en),
    .smp_data(smp_data), .clamp_level(clamp_level), .acc(acc)
  );

  blk_clamp_update #(.ACC_W(ACC_W), .DAC_W(DAC_W), .STEP_SHIFT(STEP_SHIFT)) u_update (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clamp_en(clamp_en), .acc(acc),
    .code(loop_code)
  );

  assign dac_code = clamp_en ? loop_code : DAC_W'(clamp_level);

  // R6
  short_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.close && !evt.qualified) |=> $stable(loop_code));
  // R8
  bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_en |=> $stable(loop_code));

endmodule

// File: tb/blk_clamp_loop_bench.sv
module blk_clamp_loop_bench;
  localparam int SHIFT = 4;
  localparam int TOPC  = 1023;
  localparam int CAP   = 255;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        smp_valid = 0;
  logic        smp_ready;
  logic [11:0] smp_data = '0;
  logic        clamp_strobe = 1'b0;
  logic        strobe_high = 1'b1;
  logic        clamp_en = 1'b1;
  logic [7:0]  clamp_level = '0;
  logic [9:0]  dac_code;

  int errors = 0;
  int checks = 0;
  int model  = 512;

  always #4 clk = ~clk;

  blk_clamp_loop u_blk_clamp_loop (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .clamp_strobe(clamp_strobe), .strobe_high(strobe_high),
    .clamp_en(clamp_en), .clamp_level(clamp_level), .dac_code(dac_code)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int fdiv(input int s);
    if (s >= 0) return s / (1 << SHIFT);
    return -((-s + (1 << SHIFT) - 1) / (1 << SHIFT));
  endfunction

  // One window of n valid samples; gap puts an idle cycle after each sample.
  task automatic run_win(input int n, input bit gap, input int smp, input string req);
    int sum = 0;
    int cnt = 0;
    for (int i = 0; i < (gap ? 2 * n : n); i++) begin
      @(negedge clk);
      clamp_strobe = strobe_high;
      smp_valid    = gap ? (i % 2 == 0) : 1'b1;
      smp_data     = 12'(smp);
      if (smp_valid && clamp_en && cnt < CAP) begin
        cnt++;
        sum += int'(clamp_level) - smp;
      end
    end
    @(negedge clk);
    clamp_strobe = ~strobe_high;
    smp_valid    = 1'b0;
    if (clamp_en && cnt >= 2) begin
      model = model + fdiv(sum);
      if (model < 0) model = 0;
      if (model > TOPC) model = TOPC;
    end
    @(negedge clk);
    check(req, int'(dac_code), clamp_en ? model : int'(clamp_level));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(dac_code), 512);
    check("R2", int'(smp_ready), 1);

    // R3 R5 R6 sweep: polarity, valid pattern, window length, target
    for (int pol = 0; pol < 2; pol++) begin
      @(negedge clk);
      strobe_high  = pol[0];
      clamp_strobe = ~pol[0];
      for (int gap = 0; gap < 2; gap++)
        for (int n = 0; n < 7; n++)
          for (int t = 0; t < 4; t++) begin
            clamp_level = 8'(t * 85);
            run_win(n, gap[0], (t * 85 * 13 + n * 29 + gap * 5 + pol * 11) % 300,
                    n < 2 ? "R6" : (pol == 0 ? "R3" : "R5"));
          end
    end
    check("R2", int'(smp_ready), 1);

    // R4: valid samples outside the window leave the code alone
    clamp_level = 8'd100;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 12'd3000;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
    check("R4", int'(dac_code), model);
    run_win(2, 1'b0, 100, "R4");

    // R7: drive to the upper rail, then the lower rail
    clamp_level = 8'd255;
    for (int k = 0; k < 4; k++) run_win(20, 1'b0, 0, "R7");
    check("R7", int'(dac_code), TOPC);
    clamp_level = 8'd0;
    for (int k = 0; k < 2; k++) run_win(20, 1'b0, 4095, "R7");
    check("R7", int'(dac_code), 0);

    // R10: long window, only 255 samples counted (+15 rather than +18)
    clamp_level = 8'd10;
    run_win(300, 1'b0, 9, "R10");
    check("R10", int'(dac_code), 15);

    // R8: bypass shows level, loop holds, then returns
    @(negedge clk);
    clamp_en    = 1'b0;
    clamp_level = 8'd77;
    #1;
    check("R8", int'(dac_code), 77);
    run_win(20, 1'b0, 4000, "R8");
    @(negedge clk);
    clamp_en = 1'b1;
    #1;
    check("R8", int'(dac_code), 15);
    check("R9", int'(dac_code), model);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule